// File: doc/BRIEF.md
# Single-Wire Serial Register Port Master

This block is the controller side of a register access port that reaches a physical-layer device over one shared, bidirectional bit line. The line is clocked by the same clock as the block. A request carries a direction, an address and, for writes, a data byte. The block turns the request into a serial frame. The frame starts with a one-cycle high pulse and a direction bit, then the address goes out most significant bit first. A write keeps the line driven through the data byte and a closing low bit. A read releases the line for one turnaround cycle, then shifts in the byte that the far side drives.

The pad is modelled as three separate signals: an output enable, an output value and an input value. The tri-state buffer itself sits outside the block. Only one request runs at a time. `busy` covers the whole frame, and a one-cycle `done` pulse marks its end. The byte from the most recent read stays on `rd_data` until another read completes.

Top module: `sreg_master`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy`=0, `done`=0, `rd_data`=0, `sio_oe`=1 and `sio_out`=0.
- R2: A request is accepted on a rising edge where `req_valid`=1 and `busy`=0. A `req_valid` raised while `busy`=1 is dropped. It alters neither the frame in progress nor the state after it, and no frame follows on its account.
- R3: In the first cycle after acceptance (frame cycle 0), the line is driven (`sio_oe`=1) with value 1.
- R4: In frame cycle 1 the line is driven with the direction bit: 1 for a read, 0 for a write.
- R5: In frame cycles 2 to 9 the line is driven with the 8 address bits, most significant bit first.
- R6: For a write, frame cycles 10 to 17 drive the 8 data bits, most significant bit first. Cycle 18 drives a terminating 0. `sio_oe` stays 1 in every frame cycle.
- R7: For a read, `sio_oe`=0 in frame cycles 10 to 18. Cycle 10 is a turnaround in which neither side drives. `sio_in` is sampled at the end of cycles 11 to 18, most significant bit first.
- R8: `busy`=1 and `done`=0 in all 19 frame cycles. In the cycle that follows, `done`=1 for exactly one cycle and `busy`=0.
- R9: `rd_data` shows the byte from the most recently completed read, from its `done` cycle on. Write frames and idle cycles leave it unchanged.
- R10: Whenever `busy`=0, the line is driven low (`sio_oe`=1, `sio_out`=0).
- R11: A request presented in the `done` cycle is accepted at once. Its frame cycle 0 begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame strobe |
| rd_data | output | DATA_W | Byte from the last completed read |
| sio_oe | output | 1 | Line output enable |
| sio_out | output | 1 | Line output value |
| sio_in | input | 1 | Line input value |

## Verification
The bench builds the block with its default parameters: 8 address bits, 8 data bits and a one-cycle turnaround. These defaults give the 19-cycle frame for both directions. The bench records every frame bit by bit at the pad and compares it with the expected frame. A bench-side device model with 16 registers answers reads and latches writes, so read-back checks written values, reset patterns and the all-ones and all-zeros bytes. The default settings also bring within reach back-to-back frames started in the `done` cycle, requests raised mid-frame, and driver overlap between the block and the device around the turnaround.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_DIR,
        PH_ADDR,
        PH_TURN,
        PH_RDATA,
        PH_WDATA,
        PH_TERM
    } sreg_phase_e;

endpackage

// File: rtl/sreg_seq.sv
module sreg_seq
    import sreg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    output logic        accept,
    output sreg_phase_e phase,
    output logic        is_read,
    output logic        rx_last,
    output logic        done
);

    localparam int MAXN0 = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int MAXN  = (MAXN0 > TURN_CYC) ? MAXN0 : TURN_CYC;
    localparam int CW    = $clog2(MAXN + 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] TURN_LAST = CW'(TURN_CYC - 1);

    typedef struct packed {
        sreg_phase_e   phase;
        logic [CW-1:0] cnt;
        logic          rd;
        logic          done;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    accept     = 1'b1;
                    st_d.phase = PH_SYNC;
                    st_d.rd    = req_read;
                end
            end
            PH_SYNC: st_d.phase = PH_DIR;
            PH_DIR: begin
                st_d.phase = PH_ADDR;
                st_d.cnt   = '0;
            end
            PH_ADDR: begin
                if (st_q.cnt == ADDR_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = st_q.rd ? PH_TURN : PH_WDATA;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WDATA: begin
                if (st_q.cnt == DATA_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_TERM;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_TERM: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            PH_TURN: begin
                if (st_q.cnt == TURN_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_RDATA;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_RDATA: begin
                if (st_q.cnt == DATA_LAST) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, rd: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign is_read = st_q.rd;
    assign done    = st_q.done;
    assign rx_last = (st_q.phase == PH_RDATA) && (st_q.cnt == DATA_LAST);

    // R7
    turn_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TURN && st_q.cnt == TURN_LAST) |=> (st_q.phase == PH_RDATA));

    // R2
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |=> (st_q.phase != PH_SYNC));

endmodule

// File: rtl/sreg_shifter.sv
module sreg_shifter
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  sreg_phase_e       phase,
    input  logic              rx_last,
    input  logic              din,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rdata
);

    localparam int TXW = ADDR_W + DATA_W;

    typedef struct packed {
        logic [TXW-1:0]    tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rdata;
    } shf_t;

    shf_t sh_d, sh_q;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        sh_d    = sh_q;
        rx_next = {sh_q.rx[DATA_W-2:0], din};
        if (load) begin
            sh_d.tx = {addr, wdata};
        end else if (phase == PH_ADDR || phase == PH_WDATA) begin
            sh_d.tx = {sh_q.tx[TXW-2:0], 1'b0};
        end
        if (phase == PH_RDATA) begin
            sh_d.rx = rx_next;
        end
        if (rx_last) begin
            sh_d.rdata = rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_bit = sh_q.tx[TXW-1];
    assign rdata  = sh_q.rdata;

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RDATA) |=> $stable(sh_q.rdata));

endmodule

// File: rtl/sreg_master.sv
module sreg_master
    import sreg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              sio_oe,
    output logic              sio_out,
    input  logic              sio_in
);

    sreg_phase_e phase;
    logic        accept;
    logic        is_read;
    logic        rx_last;
    logic        tx_bit;

    sreg_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TURN_CYC(TURN_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_read (req_read),
        .accept   (accept),
        .phase    (phase),
        .is_read  (is_read),
        .rx_last  (rx_last),
        .done     (done)
    );

    sreg_shifter #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .addr   (req_addr),
        .wdata  (req_wdata),
        .phase  (phase),
        .rx_last(rx_last),
        .din    (sio_in),
        .tx_bit (tx_bit),
        .rdata  (rd_data)
    );

    always_comb begin
        busy   = (phase != PH_IDLE);
        sio_oe = !((phase == PH_TURN) || (phase == PH_RDATA));
        unique case (phase)
            PH_SYNC:           sio_out = 1'b1;
            PH_DIR:            sio_out = is_read;
            PH_ADDR, PH_WDATA: sio_out = tx_bit;
            default:           sio_out = 1'b0;
        endcase
    end

    // R3
    sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sio_oe && sio_out));

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sio_oe && !sio_out));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rd_data));

endmodule

// File: tb/sreg_phy_model.sv
module sreg_phy_model #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic s_oe,
    output logic s_out
);

    typedef enum logic [2:0] {S_IDLE, S_DIR, S_ADDR, S_TURN, S_RD, S_WDAT, S_TERM} st_e;

    st_e               st;
    int                cnt;
    logic              rd;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] mem [16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cnt   <= 0;
            rd    <= 1'b0;
            a     <= '0;
            sh    <= '0;
            s_oe  <= 1'b0;
            s_out <= 1'b0;
            for (int i = 0; i < 16; i++) mem[i] <= DATA_W'(8'h3C ^ (i * 23));
        end else begin
            case (st)
                S_IDLE: if (line) st <= S_DIR;
                S_DIR: begin
                    rd  <= line;
                    cnt <= 0;
                    st  <= S_ADDR;
                end
                S_ADDR: begin
                    a <= {a[ADDR_W-2:0], line};
                    if (cnt == ADDR_W - 1) begin
                        cnt <= 0;
                        st  <= rd ? S_TURN : S_WDAT;
                    end else cnt <= cnt + 1;
                end
                S_TURN: begin
                    if (cnt == TURN_CYC - 1) begin
                        s_oe  <= 1'b1;
                        s_out <= mem[a[3:0]][DATA_W-1];
                        sh    <= mem[a[3:0]] << 1;
                        cnt   <= 0;
                        st    <= S_RD;
                    end else cnt <= cnt + 1;
                end
                S_RD: begin
                    if (cnt == DATA_W - 1) begin
                        s_oe  <= 1'b0;
                        s_out <= 1'b0;
                        st    <= S_IDLE;
                    end else begin
                        s_out <= sh[DATA_W-1];
                        sh    <= sh << 1;
                        cnt   <= cnt + 1;
                    end
                end
                S_WDAT: begin
                    sh <= {sh[DATA_W-2:0], line};
                    if (cnt == DATA_W - 1) begin
                        cnt <= 0;
                        st  <= S_TERM;
                    end else cnt <= cnt + 1;
                end
                S_TERM: begin
                    if (!line) mem[a[3:0]] <= sh;
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: tb/sreg_master_tb.sv
module sreg_master_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_read = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, sio_oe, sio_out, sio_in;
    logic [7:0] rd_data;
    logic       s_oe, s_out;

    int tests = 0;
    int fails = 0;
    int overlap = 0;
    bit finished = 0;
    logic [7:0] exp_mem [16];
    logic [7:0] last_rd = 8'h00;

    always #2 clk = ~clk;

    assign sio_in = sio_oe ? sio_out : (s_oe ? s_out : 1'b0);

    sreg_master #(.ADDR_W(8), .DATA_W(8), .TURN_CYC(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .sio_oe(sio_oe), .sio_out(sio_out), .sio_in(sio_in)
    );

    sreg_phy_model #(.ADDR_W(8), .DATA_W(8), .TURN_CYC(1)) u_phy (
        .clk(clk), .rst_n(rst_n), .line(sio_in), .s_oe(s_oe), .s_out(s_out)
    );

    always @(negedge clk) if (sio_oe && s_oe) overlap++;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drives a request at the current falling edge and records the 19 frame cycles.
    task automatic run_txn(input bit rd, input logic [7:0] a, input logic [7:0] wd,
                           input bit inject);
        logic [18:0] oe_v, out_v, busy_v, done_v;
        logic [7:0]  abits, wbits, exp_r;
        bit          issued_in_done;
        issued_in_done = (done === 1'b1);
        req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_read = 1'b0; req_addr = 8'h00; req_wdata = 8'h00;
        for (int k = 0; k < 19; k++) begin
            if (k > 0) @(negedge clk);
            oe_v[k] = sio_oe; out_v[k] = sio_out; busy_v[k] = busy; done_v[k] = done;
            if (inject && k == 5) begin
                req_valid = 1'b1; req_read = 1'b1; req_addr = 8'h09; req_wdata = 8'hEE;
            end
            if (inject && k == 6) begin
                req_valid = 1'b0; req_read = 1'b0; req_addr = 8'h00; req_wdata = 8'h00;
            end
        end
        if (issued_in_done) chk(busy_v[0] == 1'b1, "R11", "accept in done cycle", busy_v[0], 1);
        chk({oe_v[0], out_v[0]} == 2'b11, "R3", "sync bit", {oe_v[0], out_v[0]}, 2'b11);
        chk({oe_v[1], out_v[1]} == {1'b1, rd}, "R4", "direction bit", {oe_v[1], out_v[1]}, {1'b1, rd});
        for (int j = 0; j < 8; j++) abits[7-j] = out_v[2+j];
        chk(&oe_v[9:2] && abits == a, "R5", "address bits", {&oe_v[9:2], abits}, {1'b1, a});
        chk(&busy_v && !(|done_v), "R8", "busy/done in frame", {busy_v, done_v}, {19'h7FFFF, 19'h0});
        if (!rd) begin
            for (int j = 0; j < 8; j++) wbits[7-j] = out_v[10+j];
            chk(&oe_v[18:10] && wbits == wd && !out_v[18], "R6", "write data+term",
                {&oe_v[18:10], wbits, out_v[18]}, {1'b1, wd, 1'b0});
            exp_mem[a[3:0]] = wd;
        end else begin
            chk(oe_v[18:10] == 9'h0, "R7", "released line", oe_v[18:10], 0);
        end
        @(negedge clk);
        chk(done && !busy, "R8", "end strobe", {done, busy}, 2'b10);
        if (rd) begin
            exp_r = exp_mem[a[3:0]];
            chk(rd_data == exp_r, "R7", "read byte", rd_data, exp_r);
            last_rd = exp_r;
        end else begin
            chk(rd_data == last_rd, "R9", "rd_data after write", rd_data, last_rd);
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && rd_data == 8'h00 && sio_oe && !sio_out, "R1", "in reset",
            {busy, done, rd_data, sio_oe, sio_out}, 12'h002);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && rd_data == 8'h00, "R1", "after reset", {busy, done, rd_data}, 0);
        chk(sio_oe && !sio_out, "R10", "idle line", {sio_oe, sio_out}, 2'b10);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!busy && sio_oe && !sio_out, "R10", "idle line", {busy, sio_oe, sio_out}, 3'b010);
        end
    endtask

    task automatic t_basic();
        run_txn(1'b0, 8'h06, 8'h00, 1'b0);
        idle(2);
        run_txn(1'b1, 8'h06, 8'h00, 1'b0);
        idle(1);
        run_txn(1'b1, 8'h03, 8'h00, 1'b0);
        idle(1);
    endtask

    task automatic t_extremes();
        run_txn(1'b0, 8'hFF, 8'hFF, 1'b0);
        idle(1);
        run_txn(1'b1, 8'hFF, 8'h00, 1'b0);
        idle(1);
        run_txn(1'b0, 8'h05, 8'hA5, 1'b0);
        idle(3);
        chk(rd_data == last_rd, "R9", "held over idle", rd_data, last_rd);
    endtask

    task automatic t_ignored();
        run_txn(1'b0, 8'h02, 8'h5A, 1'b1);
        @(negedge clk);
        chk(!busy, "R2", "no frame from dropped request", busy, 0);
        idle(1);
        run_txn(1'b1, 8'h02, 8'h00, 1'b0);
        idle(1);
        run_txn(1'b1, 8'h09, 8'h00, 1'b0);
        idle(1);
    endtask

    task automatic t_back_to_back();
        run_txn(1'b0, 8'h0C, 8'h81, 1'b0);
        run_txn(1'b1, 8'h0C, 8'h00, 1'b0);
        run_txn(1'b1, 8'h05, 8'h00, 1'b0);
        idle(2);
        chk(overlap == 0, "R7", "no driver overlap", overlap, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'(8'h3C ^ (i * 23));
        @(negedge clk);
        t_reset();
        t_basic();
        t_extremes();
        t_ignored();
        t_back_to_back();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule